// File: doc/BRIEF.md
# AC-link interrupt status unit

This block gathers the event sources of an AC-link audio/modem controller into one status word and drives a single interrupt line to the CPU. Each source has an enable bit. A status bit can raise the interrupt only while its enable bit is set. Software reaches both words through a plain 32-bit register port. Reads are combinational. A write takes effect at the next clock edge.

The event sources are as follows:
- Five channel FIFOs report over-run and under-run strobes.
- The received-frame decoder reports three bits:
  - bit 0 of slot 0 from the primary codec;
  - bit 0 of slot 0 from the secondary codec;
  - bit 0 of slot 12.
- Two codec resume pulses.
- The codec register access engine sends three pulses:
  - a command-done pulse;
  - a status-address-received pulse;
  - a status-data-received pulse.

Sources clear in different ways. Most bits are sticky and clear when software writes 1 to them. The two codec-ready bits are not sticky: they mirror the latest received frame. Their interrupt is withdrawn by clearing the matching enable bit.

The status-done bit is fed by a small state machine that waits until both the status address and the status data have arrived. Its states are:
- `SD_IDLE`: nothing received.
- `SD_HAVE_ADDR`: the address has arrived, data pending.
- `SD_HAVE_DATA`: the data has arrived, address pending.

Its transitions are:
- idle to have-address on an address strobe alone;
- idle to have-data on a data strobe alone;
- have-address to idle on a data strobe, completing;
- have-data to idle on an address strobe, completing;
- idle to idle on both strobes in one cycle, completing;
- have-address to have-address on a repeated address strobe;
- have-data to have-data on a repeated data strobe.

Top module: `aclink_irq_unit`

## Requirements
- R1: Status bits 0..4 are FIFO error flags for PCM-out (0), PCM-in (1), mic-in (2), modem-out (3) and modem-in (4). `fifo_ovr[i]` or `fifo_udr[i]` sets bit i at the next clock edge, and the bit stays set until it is cleared.
- R2: Status bit 5 (modem GPI change) sets at the next edge when `frame_vld` and `gpi_bit` are both 1.
- R3: Status bit 6 sets on `pri_resume`. Status bit 7 sets on `sec_resume`.
- R4: Status bit 8 (command done) sets on `cmd_done`.
- R5: Status bit 9 (status done) sets only in the cycle after both `sts_addr_rx` and `sts_data_rx` have been seen since the last completion. They may arrive in either order or in the same cycle. A lone strobe of either kind leaves the bit at 0.
- R6: Status bits 10 and 11 take the values of `pri_rdy_bit` and `sec_rdy_bit` on every `frame_vld` cycle, and hold between frames. Writing 1 to them has no effect.
- R7: A write to offset 0 clears each of bits 0..9 whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R8: If a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: Offset 1 is the enable word, read/write on bits 11..0. Bit i enables status bit i. Offset 0 reads the status word. Bits 31..12 of both words read 0. Offsets 2 and 3 read 0 and ignore writes.
- R10: `irq` is registered. It is 1 in the cycle after any status bit and its enable bit are both 1, and 0 in the cycle after no such pair exists. Clearing an enable bit therefore withdraws that source's interrupt one cycle later.
- R11: Reset clears the status word, the enable word, the status-done state machine and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| fifo_ovr | input | 5 | Per-channel FIFO over-run strobes |
| fifo_udr | input | 5 | Per-channel FIFO under-run strobes |
| frame_vld | input | 1 | Received frame fields are valid this cycle |
| pri_rdy_bit | input | 1 | Slot 0 bit 0 from the primary codec |
| sec_rdy_bit | input | 1 | Slot 0 bit 0 from the secondary codec |
| gpi_bit | input | 1 | Slot 12 bit 0 of the received frame |
| pri_resume | input | 1 | Primary codec resumed from low power |
| sec_resume | input | 1 | Secondary codec resumed from low power |
| cmd_done | input | 1 | Codec register command completed |
| sts_addr_rx | input | 1 | Codec status address received |
| sts_data_rx | input | 1 | Codec status data received |
| irq | output | 1 | Interrupt to the CPU |

## Verification
The hardest situations to reach from the ports are those where two things collide in the same cycle:
- a set event arriving in the cycle that software clears the same bit;
- both status strobes landing together, or a strobe repeated before its partner arrives.

Random stimulus makes such collisions only rarely. Directed steps therefore force each collision: a completion together with its clear, address-then-data, data-then-address, simultaneous strobes and a repeated address strobe. A long random phase with dense writes to every offset then compares every cycle against a bench model of the status word, the enable word and the registered interrupt.

// File: rtl/aclink_irq_pkg.sv
package aclink_irq_pkg;

    localparam int REG_STATUS = 0;
    localparam int REG_ENABLE = 1;

    typedef enum logic [1:0] {
        SD_IDLE,
        SD_HAVE_ADDR,
        SD_HAVE_DATA
    } sd_state_e;

endpackage

// File: rtl/aclink_w1c_bank.sv
module aclink_w1c_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                // a set event wins over a clear in the same cycle
                q_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aclink_sd_fsm.sv
module aclink_sd_fsm
    import aclink_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_rx,
    input  logic data_rx,
    output logic done_o
);
    sd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        done_o  = 1'b0;
        unique case (state_q)
            SD_IDLE: begin
                if (addr_rx && data_rx) done_o  = 1'b1;
                else if (addr_rx)       state_d = SD_HAVE_ADDR;
                else if (data_rx)       state_d = SD_HAVE_DATA;
            end
            SD_HAVE_ADDR: begin
                if (data_rx) begin
                    done_o  = 1'b1;
                    state_d = SD_IDLE;
                end
            end
            SD_HAVE_DATA: begin
                if (addr_rx) begin
                    done_o  = 1'b1;
                    state_d = SD_IDLE;
                end
            end
            default: state_d = SD_IDLE;
        endcase
    end
endmodule

// File: rtl/aclink_irq_merge.sv
module aclink_irq_merge #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sts_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic pending;

    assign pending = |(sts_i & en_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pending;
    end
endmodule

// File: rtl/aclink_irq_unit.sv
module aclink_irq_unit
    import aclink_irq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int NUM_FIFO = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_FIFO-1:0] fifo_ovr,
    input  logic [NUM_FIFO-1:0] fifo_udr,
    input  logic                frame_vld,
    input  logic                pri_rdy_bit,
    input  logic                sec_rdy_bit,
    input  logic                gpi_bit,
    input  logic                pri_resume,
    input  logic                sec_resume,
    input  logic                cmd_done,
    input  logic                sts_addr_rx,
    input  logic                sts_data_rx,
    output logic                irq
);
    localparam int W1C_N = NUM_FIFO + 5;
    localparam int NSRC  = NUM_FIFO + 7;

    logic             wr_sts, wr_en, sd_done;
    logic [W1C_N-1:0] set_v, clr_v, w1c_q;
    logic [1:0]       rdy_q;
    logic [NSRC-1:0]  sts, en_q;

    assign wr_sts = reg_wr && (reg_addr == ADDR_W'(REG_STATUS));
    assign wr_en  = reg_wr && (reg_addr == ADDR_W'(REG_ENABLE));

    assign set_v = {sd_done, cmd_done, sec_resume, pri_resume,
                    frame_vld & gpi_bit, fifo_ovr | fifo_udr};
    assign clr_v = wr_sts ? reg_wdata[W1C_N-1:0] : '0;

    aclink_w1c_bank #(.N(W1C_N)) w1c_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (w1c_q)
    );

    aclink_sd_fsm sd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_rx (sts_addr_rx),
        .data_rx (sts_data_rx),
        .done_o  (sd_done)
    );

    // codec-ready bits mirror the last received frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdy_q <= '0;
        else if (frame_vld) rdy_q <= {sec_rdy_bit, pri_rdy_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= reg_wdata[NSRC-1:0];
    end

    assign sts = {rdy_q, w1c_q};

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(REG_STATUS))      reg_rdata[NSRC-1:0] = sts;
        else if (reg_addr == ADDR_W'(REG_ENABLE)) reg_rdata[NSRC-1:0] = en_q;
    end

    aclink_irq_merge #(.N(NSRC)) merge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sts_i (sts),
        .en_i  (en_q),
        .irq_o (irq)
    );
endmodule

// File: rtl/aclink_irq_chk.sv
module aclink_irq_chk #(
    parameter int NUM_FIFO = 5,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_FIFO+6:0] sts,
    input logic [NUM_FIFO+6:0] en_q,
    input logic                irq,
    input logic [NUM_FIFO-1:0] fifo_ovr,
    input logic [NUM_FIFO-1:0] fifo_udr,
    input logic                cmd_done,
    input logic                frame_vld,
    input logic                pri_rdy_bit,
    input logic                sec_rdy_bit,
    input logic                sts_addr_rx,
    input logic                sts_data_rx,
    input logic                wr_sts,
    input logic [DATA_W-1:0]   reg_wdata
);
    localparam int IDX_CMD  = NUM_FIFO + 3;
    localparam int IDX_SD   = NUM_FIFO + 4;
    localparam int IDX_PRDY = NUM_FIFO + 5;
    localparam int IDX_SRDY = NUM_FIFO + 6;

    // R1
    fifo_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_ovr | fifo_udr) != '0) |=>
        ((sts[NUM_FIFO-1:0] & $past(fifo_ovr | fifo_udr)) == $past(fifo_ovr | fifo_udr)));

    // R5
    sd_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[IDX_SD]) |-> $past(sts_addr_rx || sts_data_rx));

    // R6
    ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> (sts[IDX_PRDY] == $past(pri_rdy_bit)) && (sts[IDX_SRDY] == $past(sec_rdy_bit)));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && reg_wdata[IDX_CMD] && !cmd_done) |=> !sts[IDX_CMD]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> sts[IDX_CMD]);

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & en_q) != '0) |=> irq);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & en_q) == '0) |=> !irq);
endmodule

bind aclink_irq_unit aclink_irq_chk #(.NUM_FIFO(NUM_FIFO), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sts         (sts),
    .en_q        (en_q),
    .irq         (irq),
    .fifo_ovr    (fifo_ovr),
    .fifo_udr    (fifo_udr),
    .cmd_done    (cmd_done),
    .frame_vld   (frame_vld),
    .pri_rdy_bit (pri_rdy_bit),
    .sec_rdy_bit (sec_rdy_bit),
    .sts_addr_rx (sts_addr_rx),
    .sts_data_rx (sts_data_rx),
    .wr_sts      (wr_sts),
    .reg_wdata   (reg_wdata)
);

// File: tb/aclink_irq_unit_tb_top.sv
module aclink_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  fifo_ovr = '0, fifo_udr = '0;
    logic        frame_vld = 0, pri_rdy_bit = 0, sec_rdy_bit = 0, gpi_bit = 0;
    logic        pri_resume = 0, sec_resume = 0, cmd_done = 0;
    logic        sts_addr_rx = 0, sts_data_rx = 0;
    logic        irq;

    always #4 clk = ~clk;

    aclink_irq_unit dut_i (.*);

    int n_chk = 0, n_fail = 0;
    logic [11:0] sts_m = '0, en_m = '0;
    logic        irq_m = 1'b0, have_a = 1'b0, have_d = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        if (a == 2'd0)      return {20'b0, sts_m};
        else if (a == 2'd1) return {20'b0, en_m};
        else                return 32'b0;
    endfunction

    task automatic idle_inputs();
        reg_wr = 0; reg_wdata = '0; fifo_ovr = '0; fifo_udr = '0;
        frame_vld = 0; pri_rdy_bit = 0; sec_rdy_bit = 0; gpi_bit = 0;
        pri_resume = 0; sec_resume = 0; cmd_done = 0;
        sts_addr_rx = 0; sts_data_rx = 0;
    endtask

    // model update from the requirements, using pre-edge values
    task automatic model_edge();
        logic [11:0] s;
        logic        sd;
        irq_m = |(sts_m & en_m);                                  // R10
        sd = (sts_addr_rx && sts_data_rx) || (have_a && sts_data_rx) || (have_d && sts_addr_rx);
        if (sd) begin have_a = 0; have_d = 0; end
        else begin
            if (sts_addr_rx) have_a = 1;
            if (sts_data_rx) have_d = 1;
        end
        s = sts_m;
        for (int i = 0; i < 10; i++)
            if (reg_wr && reg_addr == 2'd0 && reg_wdata[i]) s[i] = 1'b0;   // R7
        for (int i = 0; i < 5; i++)
            if (fifo_ovr[i] || fifo_udr[i]) s[i] = 1'b1;                   // R1
        if (frame_vld && gpi_bit) s[5] = 1'b1;                             // R2
        if (pri_resume) s[6] = 1'b1;                                       // R3
        if (sec_resume) s[7] = 1'b1;
        if (cmd_done)   s[8] = 1'b1;                                       // R4
        if (sd)         s[9] = 1'b1;                                       // R5
        if (frame_vld) begin s[10] = pri_rdy_bit; s[11] = sec_rdy_bit; end // R6
        if (reg_wr && reg_addr == 2'd1) en_m = reg_wdata[11:0];            // R9
        sts_m = s;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(irq == irq_m, "R10 irq", {31'b0, irq}, {31'b0, irq_m});
        check(reg_rdata == exp_rdata(reg_addr), "R9 readback", reg_rdata, exp_rdata(reg_addr));
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check(reg_rdata == 32'h0, "R11 status after reset", reg_rdata, 0);
        check(irq == 1'b0, "R11 irq after reset", {31'b0, irq}, 0);
        rst_n = 1'b1;
        reg_addr = 2'd1; cycle();
        check(reg_rdata == 32'h0, "R11 enable after reset", reg_rdata, 0);

        // R10 latency: enable FIFO 4, raise it, clear it
        reg_addr = 2'd1; reg_wr = 1; reg_wdata = 32'h10; cycle();
        reg_addr = 2'd0; fifo_ovr = 5'b10000; cycle();
        check(reg_rdata[4] == 1'b1, "R1 fifo bit4", reg_rdata, 32'h10);
        check(irq == 1'b0, "R10 irq not yet", {31'b0, irq}, 0);
        cycle();
        check(irq == 1'b1, "R10 irq raised", {31'b0, irq}, 1);
        reg_wr = 1; reg_wdata = 32'h0; cycle();
        check(reg_rdata[4] == 1'b1, "R7 write 0 no effect", reg_rdata, 32'h10);
        reg_wr = 1; reg_wdata = 32'h10; cycle();
        check(reg_rdata[4] == 1'b0, "R7 w1c cleared", reg_rdata, 0);
        check(irq == 1'b1, "R10 irq one more cycle", {31'b0, irq}, 1);
        cycle();
        check(irq == 1'b0, "R10 irq dropped", {31'b0, irq}, 0);

        // R8 set wins over clear
        cmd_done = 1; cycle();
        cmd_done = 1; reg_wr = 1; reg_wdata = 32'h100; cycle();
        check(reg_rdata[8] == 1'b1, "R8 set over clear", reg_rdata, 32'h100);

        // R5 orderings
        reg_wr = 1; reg_wdata = 32'h200; cycle();
        sts_addr_rx = 1; cycle();
        check(reg_rdata[9] == 1'b0, "R5 addr alone", reg_rdata, 0);
        sts_addr_rx = 1; cycle();
        check(reg_rdata[9] == 1'b0, "R5 repeated addr", reg_rdata, 0);
        sts_data_rx = 1; cycle();
        check(reg_rdata[9] == 1'b1, "R5 addr then data", reg_rdata, 32'h200);
        reg_wr = 1; reg_wdata = 32'h200; cycle();
        sts_data_rx = 1; cycle();
        check(reg_rdata[9] == 1'b0, "R5 data alone", reg_rdata, 0);
        sts_addr_rx = 1; cycle();
        check(reg_rdata[9] == 1'b1, "R5 data then addr", reg_rdata, 32'h200);
        reg_wr = 1; reg_wdata = 32'h200; cycle();
        sts_addr_rx = 1; sts_data_rx = 1; cycle();
        check(reg_rdata[9] == 1'b1, "R5 same cycle", reg_rdata, 32'h200);

        // R2 / R3 / R4 / R6
        frame_vld = 1; gpi_bit = 1; pri_rdy_bit = 1; cycle();
        check(reg_rdata[5] && reg_rdata[10] && !reg_rdata[11], "R2 R6 frame fields", reg_rdata, 32'h420);
        pri_resume = 1; sec_resume = 1; cycle();
        check(reg_rdata[7:6] == 2'b11, "R3 resume bits", reg_rdata, 32'hC0);
        check(reg_rdata[8] == 1'b1, "R4 cmd done held", reg_rdata, 32'h100);
        reg_wr = 1; reg_wdata = 32'hC00; cycle();
        check(reg_rdata[10] == 1'b1, "R6 w1 ignored", reg_rdata, 32'h400);
        reg_wr = 1; reg_wdata = 32'h3FF; cycle();
        reg_addr = 2'd1; reg_wr = 1; reg_wdata = 32'hFFFF_F400; cycle();
        check(reg_rdata == 32'h0000_0400, "R9 upper bits zero", reg_rdata, 32'h400);
        cycle();
        check(irq == 1'b1, "R6 ready irq", {31'b0, irq}, 1);
        reg_wr = 1; reg_wdata = 32'h0; cycle();
        cycle();
        check(irq == 1'b0, "R6 enable clear drops irq", {31'b0, irq}, 0);
        reg_addr = 2'd2; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cycle();
        check(reg_rdata == 32'h0, "R9 offset 2 reads 0", reg_rdata, 0);
        reg_addr = 2'd1; cycle();
        check(reg_rdata == 32'h0, "R9 offset 2 write ignored", reg_rdata, 0);

        // constrained random phase, R1 R7 R8 R10 by model
        for (int n = 0; n < 4000; n++) begin
            reg_addr = 2'($urandom_range(0, 3));
            reg_wr = ($urandom_range(0, 4) == 0);
            reg_wdata = $urandom;
            if ($urandom_range(0, 7) == 0) fifo_ovr = 5'($urandom);
            if ($urandom_range(0, 7) == 0) fifo_udr = 5'($urandom);
            frame_vld = ($urandom_range(0, 3) == 0);
            pri_rdy_bit = 1'($urandom); sec_rdy_bit = 1'($urandom);
            gpi_bit = ($urandom_range(0, 3) == 0);
            pri_resume = ($urandom_range(0, 15) == 0);
            sec_resume = ($urandom_range(0, 15) == 0);
            cmd_done = ($urandom_range(0, 9) == 0);
            sts_addr_rx = ($urandom_range(0, 5) == 0);
            sts_data_rx = ($urandom_range(0, 5) == 0);
            cycle();
        end

        finish_run();
    end
endmodule